// File: doc/BRIEF.md
# Four-Mode Power Sequencer

This block steps a chip through four operating modes (normal, slow, idle and power-off). It drives a gated core clock, a set of gated peripheral clocks, a PLL enable, a select that decides whether the core runs from the PLL or from the reference clock, and the enable of the internal power domain. Software requests a mode by writing a two-bit code with a one-cycle write strobe. Each mode has its own wake source. Idle ends on any interrupt line. Power-off ends only on the external wake pin or the RTC alarm.

Leaving slow mode turns the PLL on again at once. The core stays on the reference clock until a programmable lock count has run out, and only then moves to the PLL. A wake from power-off first raises the power-domain enable and waits a fixed settling count. It then enters normal mode with a one-cycle reset-release pulse. Every gated clock changes its enable only on the falling edge of the clock, so a gated output never carries a shortened high pulse. A strap input chooses between the crystal and the external clock as the reference source, and the block captures it while reset is held.

Top module: `pmu_top`

## Requirements
- R1: While `rst` is high and in the first cycles after it, the mode is normal (`mode_o`=0), `pll_en_o`=1, `core_on_ref_o`=0, `pwr_dom_en_o`=1, `rst_release_o`=0 and the peripheral mask is all ones.
- R2: In normal mode the core clock runs, and peripheral clock i runs exactly when bit i of the mask (last written through `mask_wr_i`/`mask_wdata_i`, 1 = run) is set.
- R3: Writing code 1 in normal mode enters slow mode on the sampling edge: `pll_en_o`=0, `core_on_ref_o`=1, and the core and peripheral clocks keep running. In slow mode, writes of codes 1, 2 and 3 are ignored.
- R4: Writing code 2 in normal mode enters idle one cycle after the edge that samples the write. In idle the core clock is stopped, the peripheral clocks follow the mask and the PLL stays on. Any set bit of `irq_i` returns to normal on the next edge, while `ext_wake_i`, `rtc_alarm_i` and mode writes are ignored.
- R5: Writing code 3 in normal mode enters power-off on the sampling edge: all clocks stopped, `pll_en_o`=0, `pwr_dom_en_o`=0. `irq_i` is ignored. `ext_wake_i` or `rtc_alarm_i` starts the wake sequence.
- R6: Writing code 0 in slow mode sets `pll_en_o` on the sampling edge. `core_on_ref_o` stays 1 and `mode_o` stays 1 for `lock_count_i`+1 cycles, after which the block is in normal mode with `core_on_ref_o`=0.
- R7: On a wake from power-off, `pwr_dom_en_o` rises on the wake edge. `mode_o` stays 3 with clocks stopped for SETTLE_CYC+1 cycles. Then normal mode begins, and `rst_release_o` is high for exactly its first cycle.
- R8: Every gated clock output is low whenever `clk` is low, and equals `clk` during the high phase when its enable is set.
- R9: `ref_sel_o` holds the value of `ext_ref_strap_i` seen while `rst` was high (0 = crystal, 1 = external clock), and later changes of the strap have no effect.
- R10: `mode_o` encodes 0 normal, 1 slow (including lock wait), 2 idle, 3 power-off (including settling). A write of code 0 in normal mode changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_wdata_i | input | 2 | Requested mode code |
| mask_wr_i | input | 1 | Peripheral mask write strobe |
| mask_wdata_i | input | NPERIPH | New peripheral mask |
| lock_count_i | input | LOCK_W | PLL lock wait length |
| irq_i | input | NIRQ | Interrupt lines (idle wake) |
| ext_wake_i | input | 1 | External wake pin |
| rtc_alarm_i | input | 1 | RTC alarm |
| ext_ref_strap_i | input | 1 | Reference source strap |
| core_clk_o | output | 1 | Gated core clock |
| periph_clk_o | output | NPERIPH | Gated peripheral clocks |
| pll_en_o | output | 1 | PLL enable |
| core_on_ref_o | output | 1 | 1 = core clock taken from reference |
| ref_sel_o | output | 1 | 0 = crystal, 1 = external clock |
| pwr_dom_en_o | output | 1 | Internal power-domain enable |
| rst_release_o | output | 1 | Reset-release pulse after power-on |
| mode_o | output | 2 | Current mode code |

## Verification
The mode sequencer is driven with a chain of writes and wake events that reaches every mode from every legal predecessor. The chain also places wrong-source events in each mode (an interrupt in power-off, the wake pin in idle, an idle write in slow mode) and checks that they leave the outputs unchanged. Those events separate a design that wakes on any source from one that honours each mode's own source. Cycle-exact runs through lock wait, idle entry and settling measure the durations, so an off-by-one count or an entry on the wrong edge shows up. Checks in the low clock phase separate a glitch-free gate from one that can pass a partial pulse.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_SLOW   = 2'd1,
        MODE_IDLE   = 2'd2,
        MODE_OFF    = 2'd3
    } pmu_mode_e;

    typedef enum logic [2:0] {
        ST_RUN, ST_SLOW, ST_LOCK, ST_IDLE, ST_OFF, ST_SETTLE
    } pmu_state_e;

    typedef struct packed {
        logic core_en;
        logic pll_en;
        logic on_ref;
        logic dom_en;
        logic periph_on;
    } pmu_ctl_t;

    function automatic pmu_ctl_t ctl_for(pmu_state_e s);
        pmu_ctl_t c;
        case (s)
            ST_SLOW:   c = '{core_en: 1'b1, pll_en: 1'b0, on_ref: 1'b1, dom_en: 1'b1, periph_on: 1'b1};
            ST_LOCK:   c = '{core_en: 1'b1, pll_en: 1'b1, on_ref: 1'b1, dom_en: 1'b1, periph_on: 1'b1};
            ST_IDLE:   c = '{core_en: 1'b0, pll_en: 1'b1, on_ref: 1'b0, dom_en: 1'b1, periph_on: 1'b1};
            ST_OFF:    c = '{core_en: 1'b0, pll_en: 1'b0, on_ref: 1'b1, dom_en: 1'b0, periph_on: 1'b0};
            ST_SETTLE: c = '{core_en: 1'b0, pll_en: 1'b1, on_ref: 1'b1, dom_en: 1'b1, periph_on: 1'b0};
            default:   c = '{core_en: 1'b1, pll_en: 1'b1, on_ref: 1'b0, dom_en: 1'b1, periph_on: 1'b1};
        endcase
        return c;
    endfunction

    function automatic pmu_mode_e mode_of(pmu_state_e s);
        case (s)
            ST_SLOW, ST_LOCK:  return MODE_SLOW;
            ST_IDLE:           return MODE_IDLE;
            ST_OFF, ST_SETTLE: return MODE_OFF;
            default:           return MODE_NORMAL;
        endcase
    endfunction

endpackage

// File: rtl/pmu_down_cnt.sv
module pmu_down_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/pmu_clk_gate.sv
module pmu_clk_gate (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic gclk
);
    logic en_q;

    // Enable moves only while clk is low, so the AND never clips a high phase.
    always_ff @(negedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else
            en_q <= en;
    end

    assign gclk = clk & en_q;
endmodule

// File: rtl/pmu_seq.sv
module pmu_seq
    import pmu_pkg::*;
#(
    parameter int NIRQ       = 3,
    parameter int LOCK_W     = 8,
    parameter int SETTLE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  pmu_mode_e         mode_req,
    input  logic [LOCK_W-1:0] lock_count,
    input  logic [NIRQ-1:0]   irq,
    input  logic              ext_wake,
    input  logic              rtc_alarm,
    output pmu_state_e        state,
    output logic              rst_release
);
    localparam logic [LOCK_W-1:0] SETTLE_VAL = LOCK_W'(SETTLE_CYC);

    pmu_state_e state_q, state_d;
    logic idle_pend_q;
    logic cnt_load, cnt_zero, rel_q;
    logic [LOCK_W-1:0] cnt_val;

    pmu_down_cnt #(.W(LOCK_W)) i_cnt (
        .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
    );

    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = lock_count;
        case (state_q)
            ST_RUN: begin
                if (idle_pend_q)
                    state_d = ST_IDLE;
                else if (mode_wr && mode_req == MODE_SLOW)
                    state_d = ST_SLOW;
                else if (mode_wr && mode_req == MODE_OFF)
                    state_d = ST_OFF;
            end
            ST_SLOW: begin
                if (mode_wr && mode_req == MODE_NORMAL) begin
                    state_d  = ST_LOCK;
                    cnt_load = 1'b1;
                end
            end
            ST_LOCK:   if (cnt_zero) state_d = ST_RUN;
            ST_IDLE:   if (|irq) state_d = ST_RUN;
            ST_OFF: begin
                if (ext_wake || rtc_alarm) begin
                    state_d  = ST_SETTLE;
                    cnt_load = 1'b1;
                    cnt_val  = SETTLE_VAL;
                end
            end
            ST_SETTLE: if (cnt_zero) state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_RUN;
            idle_pend_q <= 1'b0;
            rel_q       <= 1'b0;
        end else begin
            state_q     <= state_d;
            idle_pend_q <= (state_q == ST_RUN) && !idle_pend_q
                           && mode_wr && (mode_req == MODE_IDLE);
            rel_q       <= (state_q == ST_SETTLE) && cnt_zero;
        end
    end

    assign state       = state_q;
    assign rst_release = rel_q;

    // R4: idle entered only after the pending cycle
    a_r4_idle_after_pend: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q == ST_IDLE) |-> $past(idle_pend_q));

    // R4: any interrupt ends idle
    a_r4_idle_wake: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && |irq) |=> (state_q == ST_RUN));

    // R5: power-off holds without a legal wake source
    a_r5_off_hold: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OFF && !ext_wake && !rtc_alarm) |=> (state_q == ST_OFF));

    // R6: lock wait continues while the counter is running
    a_r6_lock_hold: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOCK && !cnt_zero) |=> (state_q == ST_LOCK));

    // R7: release pulse only right after settling, and only one cycle long
    a_r7_release_src: assert property (@(posedge clk) disable iff (rst)
        rel_q |-> ($past(state_q == ST_SETTLE) && state_q == ST_RUN));
    a_r7_release_single: assert property (@(posedge clk) disable iff (rst)
        rel_q |=> !rel_q);
endmodule

// File: rtl/pmu_top.sv
module pmu_top
    import pmu_pkg::*;
#(
    parameter int NPERIPH    = 4,
    parameter int NIRQ       = 3,
    parameter int LOCK_W     = 8,
    parameter int SETTLE_CYC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_wr_i,
    input  logic [1:0]         mode_wdata_i,
    input  logic               mask_wr_i,
    input  logic [NPERIPH-1:0] mask_wdata_i,
    input  logic [LOCK_W-1:0]  lock_count_i,
    input  logic [NIRQ-1:0]    irq_i,
    input  logic               ext_wake_i,
    input  logic               rtc_alarm_i,
    input  logic               ext_ref_strap_i,
    output logic               core_clk_o,
    output logic [NPERIPH-1:0] periph_clk_o,
    output logic               pll_en_o,
    output logic               core_on_ref_o,
    output logic               ref_sel_o,
    output logic               pwr_dom_en_o,
    output logic               rst_release_o,
    output logic [1:0]         mode_o
);
    pmu_state_e         state;
    pmu_ctl_t           ctl;
    logic [NPERIPH-1:0] mask_q;
    logic               ref_sel_q;

    pmu_seq #(.NIRQ(NIRQ), .LOCK_W(LOCK_W), .SETTLE_CYC(SETTLE_CYC)) i_seq (
        .clk(clk), .rst(rst),
        .mode_wr(mode_wr_i), .mode_req(pmu_mode_e'(mode_wdata_i)),
        .lock_count(lock_count_i), .irq(irq_i),
        .ext_wake(ext_wake_i), .rtc_alarm(rtc_alarm_i),
        .state(state), .rst_release(rst_release_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q    <= '1;
            ref_sel_q <= ext_ref_strap_i;
        end else if (mask_wr_i) begin
            mask_q <= mask_wdata_i;
        end
    end

    assign ctl = ctl_for(state);

    pmu_clk_gate i_core_gate (.clk(clk), .rst(rst), .en(ctl.core_en), .gclk(core_clk_o));

    for (genvar g = 0; g < NPERIPH; g++) begin : g_periph
        pmu_clk_gate i_gate (
            .clk(clk), .rst(rst),
            .en(ctl.periph_on & mask_q[g]),
            .gclk(periph_clk_o[g])
        );
    end

    assign pll_en_o      = ctl.pll_en;
    assign core_on_ref_o = ctl.on_ref;
    assign pwr_dom_en_o  = ctl.dom_en;
    assign ref_sel_o     = ref_sel_q;
    assign mode_o        = mode_of(state);

    // R5: power domain may only come up together with a settle start
    a_r5_dom_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_dom_en_o) |-> $past(ext_wake_i || rtc_alarm_i));

    // R9: reference selection is frozen outside reset
    a_r9_ref_frozen: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(ref_sel_o));
endmodule

// File: tb/test_pmu_top.sv
`timescale 1ns/1ps
module test_pmu_top;
    localparam int NP = 4, NI = 3, LW = 8, SC = 3, LOCK = 5;

    logic clk = 1'b0, rst = 1'b1;
    logic mode_wr = 0, mask_wr = 0, ext_wake = 0, rtc = 0, strap = 1;
    logic [1:0] mode_wd = 0;
    logic [NP-1:0] mask_wd = 0;
    logic [NI-1:0] irq = 0;
    logic [LW-1:0] lock_cnt = LW'(LOCK);
    logic core_clk, pll_en, on_ref, ref_sel, dom_en, rel;
    logic [NP-1:0] pclk;
    logic [1:0] mode;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pmu_top #(.NPERIPH(NP), .NIRQ(NI), .LOCK_W(LW), .SETTLE_CYC(SC)) i_pmu_top (
        .clk(clk), .rst(rst), .mode_wr_i(mode_wr), .mode_wdata_i(mode_wd),
        .mask_wr_i(mask_wr), .mask_wdata_i(mask_wd), .lock_count_i(lock_cnt),
        .irq_i(irq), .ext_wake_i(ext_wake), .rtc_alarm_i(rtc),
        .ext_ref_strap_i(strap), .core_clk_o(core_clk), .periph_clk_o(pclk),
        .pll_en_o(pll_en), .core_on_ref_o(on_ref), .ref_sel_o(ref_sel),
        .pwr_dom_en_o(dom_en), .rst_release_o(rel), .mode_o(mode)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr_mode(input logic [1:0] v);
        mode_wr = 1; mode_wd = v; tick(); mode_wr = 0;
    endtask

    task automatic pulse(input int op);
        case (op)
            1: irq = 3'b010;
            2: ext_wake = 1;
            default: rtc = 1;
        endcase
        tick();
        irq = 0; ext_wake = 0; rtc = 0;
    endtask

    // {op[2:0], val[1:0], mode[1:0], pll, ref, pwr, core}; op 0 write, 1 irq, 2 ext, 3 rtc
    localparam logic [10:0] VEC [0:13] = '{
        {3'd0, 2'd1, 2'd1, 4'b0111},  // R3 enter slow
        {3'd0, 2'd2, 2'd1, 4'b0111},  // R3 idle write ignored in slow
        {3'd0, 2'd0, 2'd0, 4'b1011},  // R6 leave slow
        {3'd0, 2'd2, 2'd2, 4'b1010},  // R4 enter idle
        {3'd2, 2'd0, 2'd2, 4'b1010},  // R4 wake pin ignored in idle
        {3'd0, 2'd1, 2'd2, 4'b1010},  // R4 write ignored in idle
        {3'd1, 2'd0, 2'd0, 4'b1011},  // R4 irq wakes idle
        {3'd0, 2'd3, 2'd3, 4'b0100},  // R5 enter off
        {3'd1, 2'd0, 2'd3, 4'b0100},  // R5 irq ignored in off
        {3'd3, 2'd0, 2'd0, 4'b1011},  // R5 rtc wakes
        {3'd0, 2'd3, 2'd3, 4'b0100},  // R5 enter off again
        {3'd2, 2'd0, 2'd0, 4'b1011},  // R5 wake pin wakes
        {3'd0, 2'd0, 2'd0, 4'b1011},  // R10 normal write in normal
        {3'd0, 2'd1, 2'd1, 4'b0111}   // R3 slow again
    };

    initial begin
        #(5 * 100000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        tick(); tick();
        // R1 reset state
        chk(mode == 2'd0, "R1 mode", mode, 0);
        chk(pll_en && !on_ref && dom_en && !rel, "R1 controls",
            {pll_en, on_ref, dom_en, rel}, 4'b1010);
        chk(core_clk == 1'b1 && pclk == 4'hF, "R1 clocks", {core_clk, pclk}, 5'h1F);
        // R9 strap captured in reset
        chk(ref_sel == 1'b1, "R9 strap", ref_sel, 1);
        strap = 0; tick(); tick();
        chk(ref_sel == 1'b1, "R9 strap frozen", ref_sel, 1);

        // R2 mask
        mask_wr = 1; mask_wd = 4'b0101; tick(); mask_wr = 0; tick(); tick();
        chk(pclk == 4'b0101, "R2 mask", pclk, 4'b0101);
        chk(core_clk == 1'b1, "R2 core", core_clk, 1);
        // R8 low phase
        @(negedge clk); #0.5;
        chk(core_clk == 0 && pclk == 0, "R8 low phase", {core_clk, pclk}, 0);
        tick();

        // table walk
        for (int i = 0; i < 14; i++) begin
            logic [10:0] v;
            v = VEC[i];
            if (v[10:8] == 3'd0) wr_mode(v[7:6]); else pulse(int'(v[10:8]));
            repeat (12) tick();
            chk(mode == v[5:4], $sformatf("R10 vec%0d mode", i), mode, v[5:4]);
            chk({pll_en, on_ref, dom_en} == v[3:1], $sformatf("R5 vec%0d ctl", i),
                {pll_en, on_ref, dom_en}, v[3:1]);
            chk(core_clk == v[0], $sformatf("R4 vec%0d core", i), core_clk, v[0]);
            chk(pclk == ((v[5:4] == 2'd3) ? 4'b0000 : 4'b0101),
                $sformatf("R2 vec%0d periph", i), pclk,
                (v[5:4] == 2'd3) ? 0 : 5);
        end

        // R6 lock wait timing (block is in slow now)
        wr_mode(2'd0);
        chk(pll_en && on_ref && mode == 2'd1, "R6 lock start",
            {pll_en, on_ref, mode}, 4'b1101);
        repeat (LOCK) tick();
        chk(on_ref && mode == 2'd1, "R6 lock last", {on_ref, mode}, 3'b101);
        tick();
        chk(!on_ref && mode == 2'd0, "R6 lock done", {on_ref, mode}, 0);

        // R4 idle entry delay
        tick();
        wr_mode(2'd2);
        chk(mode == 2'd0, "R4 idle delay", mode, 0);
        tick();
        chk(mode == 2'd2, "R4 idle entered", mode, 2);
        pulse(1);
        chk(mode == 2'd0, "R4 irq wake edge", mode, 0);

        // R7 settle and release
        tick();
        wr_mode(2'd3);
        chk(!dom_en && !pll_en, "R5 off ctl", {dom_en, pll_en}, 0);
        pulse(2);
        chk(dom_en && mode == 2'd3 && !rel, "R7 settle start", {dom_en, mode, rel}, 4'b1110);
        repeat (SC) tick();
        chk(mode == 2'd3 && !rel, "R7 settle last", {mode, rel}, 3'b110);
        tick();
        chk(mode == 2'd0 && rel, "R7 release", {mode, rel}, 3'b001);
        tick();
        chk(!rel, "R7 release single", rel, 0);
        tick(); tick();
        chk(core_clk == 1'b1, "R7 core back", core_clk, 1);

        // R9 second reset with strap low
        rst = 1; repeat (2) tick(); rst = 0; strap = 1; tick(); tick();
        chk(ref_sel == 1'b0, "R9 strap low", ref_sel, 0);
        chk(pclk == 4'hF, "R1 mask after reset", pclk, 4'hF);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule